// File: doc/BRIEF.md
# Card Bus Clock Generator

This block produces the bus clock for an SD/MMC card from the fast system clock. Software writes a 16-bit rate word. The word holds a 4-bit divider and a 12-bit power-of-two prescaler. The output period is the product of the two stages. The clock is started and stopped with strobe bits in a control word.

A stop request lets the current output period run to its end, so the card never sees a shortened high or low phase. A new rate written while the clock runs waits for the next period boundary. A soft-reset strobe stops the clock at once and restores the default rate. After a soft reset, the clock stays held until software has issued eight plain start writes.

Host access is a write strobe with an address and data, plus a combinational read port addressed separately. The block has no card protocol logic and does not choose a rate by itself.

Top module: `cclk_top`

## Requirements
- R1: Address 1 holds the rate word. The divider is in bits [3:0] and the prescaler in bits [15:4]. Reading address 1 returns exactly the last value written there. Address 0 (control) reads as zero.
- R2: While running, each output period lasts P = (D+1) x M input cycles. M is 1 when the prescaler field is 0, and 2 x prescaler otherwise. The output is high for floor(P/2) cycles and low for the rest of the period.
- R3: A divider field of 0 behaves exactly like a divider of 1.
- R4: A control write with bit 1 (start) set, while stopped, drives the card clock high in the first cycle after the write. It sets the running status in that same cycle.
- R5: A control write with bit 0 (stop) set lets the current period finish with full-length high and low phases. The clock then stays low and the running status clears at the period boundary. A stop while already stopped has no effect.
- R6: A control write with both start and stop set is treated as a start. A clock that is already running keeps running.
- R7: A rate written while running takes effect only at the next period boundary. The period in progress keeps the old length.
- R8: A control write with bit 3 (soft reset) set stops the clock immediately and restores the rate word to 0x0001. The start bit in that same write is ignored. The clock then stays stopped until eight control writes with start set and reset clear have arrived. The eighth of these starts the clock.
- R9: Address 2 is the status word. Bit 8 reads 1 exactly while the card clock is running, and all other bits read 0.
- R10: After hardware reset, the clock is stopped and low, and the rate word is 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 rate) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 rate, 2 status) |
| rd_data | output | 16 | Read data, combinational |
| card_clk | output | 1 | Generated card bus clock |
| clk_running | output | 1 | High while the card clock is running |

## Verification
The hardest state to reach is the middle of the soft-reset recovery. Seven plain starts must be seen to leave the clock held, and the eighth must release it, while a combined reset-and-start write must not count toward the eight. The bench drives the exact write sequence and checks the running status after the combined write, after the seventh start and after the eighth. Another hard case is a stop or a rate change that lands inside a high phase. For this, the bench writes on the first high sample after a start and then measures the whole period around that write, so any shortened phase shows up as a wrong count.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
    localparam int ADDR_W       = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_RATE = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
    localparam int B_STOP       = 0;
    localparam int B_START      = 1;
    localparam int B_SRST       = 3;
    localparam int STAT_RUN_BIT = 8;
endpackage

// File: rtl/cclk_regs.sv
module cclk_regs
    import cclk_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int PRE_W      = 12,
    parameter int RST_STARTS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DIV_W+PRE_W-1:0] wr_data,
    output logic [DIV_W+PRE_W-1:0] rate_o,
    output logic                   start_o,
    output logic                   stop_o,
    output logic                   sreset_o,
    output logic                   recov_o
);
    localparam int RATE_W = DIV_W + PRE_W;
    localparam int CNT_W  = $clog2(RST_STARTS + 1);
    localparam logic [RATE_W-1:0] RATE_DEF = RATE_W'(1);

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              rec;
        logic [CNT_W-1:0]  rcnt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        start_o  = 1'b0;
        stop_o   = 1'b0;
        sreset_o = 1'b0;
        if (wr_en && wr_addr == A_RATE) begin
            r_d.rate = wr_data;
        end
        if (wr_en && wr_addr == A_CTRL) begin
            if (wr_data[B_SRST]) begin
                sreset_o = 1'b1;
                r_d.rate = RATE_DEF;
                r_d.rec  = 1'b1;
                r_d.rcnt = '0;
            end else begin
                stop_o = wr_data[B_STOP];
                if (wr_data[B_START]) begin
                    if (!r_q.rec) begin
                        start_o = 1'b1;
                    end else if (r_q.rcnt == CNT_W'(RST_STARTS - 1)) begin
                        r_d.rec  = 1'b0;
                        r_d.rcnt = '0;
                        start_o  = 1'b1;
                    end else begin
                        r_d.rcnt = r_q.rcnt + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{rate: RATE_DEF, rec: 1'b0, rcnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rate_o  = r_q.rate;
    assign recov_o = r_q.rec;
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen #(
    parameter int DIV_W = 4,
    parameter int PRE_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DIV_W+PRE_W-1:0] rate_i,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic                   sreset_i,
    output logic                   card_clk_o,
    output logic                   running_o
);
    localparam int RATE_W = DIV_W + PRE_W;
    localparam int PER_W  = DIV_W + PRE_W + 2;
    localparam logic [RATE_W-1:0] RATE_DEF = RATE_W'(1);

    typedef struct packed {
        logic             run;
        logic             pend;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] half;
        logic             cclk;
    } gen_t;

    function automatic logic [PER_W-1:0] period_of(input logic [RATE_W-1:0] r);
        logic [PER_W-1:0] de;
        logic [PER_W-1:0] m;
        de = (r[DIV_W-1:0] == '0) ? PER_W'(2)
                                  : PER_W'(r[DIV_W-1:0]) + PER_W'(1);
        m  = (r[RATE_W-1:DIV_W] == '0) ? PER_W'(1)
                                       : PER_W'(r[RATE_W-1:DIV_W]) << 1;
        return de * m;
    endfunction

    gen_t g_d, g_q;
    logic load;

    always_comb begin
        g_d  = g_q;
        load = 1'b0;
        if (sreset_i) begin
            g_d.run  = 1'b0;
            g_d.pend = 1'b0;
            g_d.cnt  = '0;
        end else if (start_i && !g_q.run) begin
            g_d.run  = 1'b1;
            g_d.pend = 1'b0;
            g_d.cnt  = '0;
            load     = 1'b1;
        end else begin
            if (start_i) begin
                g_d.pend = 1'b0;
            end else if (stop_i && g_q.run) begin
                g_d.pend = 1'b1;
            end
            if (g_q.run) begin
                if (g_q.cnt == g_q.per - PER_W'(1)) begin
                    g_d.cnt = '0;
                    if (g_d.pend) begin
                        g_d.run  = 1'b0;
                        g_d.pend = 1'b0;
                    end else begin
                        load = 1'b1;
                    end
                end else begin
                    g_d.cnt = g_q.cnt + PER_W'(1);
                end
            end
        end
        if (load) begin
            g_d.per  = period_of(rate_i);
            g_d.half = g_d.per >> 1;
        end
        g_d.cclk = g_d.run && (g_d.cnt < g_d.half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{run: 1'b0, pend: 1'b0, cnt: '0,
                     per: period_of(RATE_DEF), half: period_of(RATE_DEF) >> 1,
                     cclk: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

    assign card_clk_o = g_q.cclk;
    assign running_o  = g_q.run;
endmodule

// File: rtl/cclk_top.sv
module cclk_top
    import cclk_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int PRE_W      = 12,
    parameter int RST_STARTS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DIV_W+PRE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DIV_W+PRE_W-1:0] rd_data,
    output logic                   card_clk,
    output logic                   clk_running
);
    localparam int RATE_W = DIV_W + PRE_W;

    logic [RATE_W-1:0] rate_w;
    logic start_w, stop_w, sreset_w, recov_w;

    cclk_regs #(.DIV_W(DIV_W), .PRE_W(PRE_W), .RST_STARTS(RST_STARTS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rate_o(rate_w), .start_o(start_w),
        .stop_o(stop_w), .sreset_o(sreset_w), .recov_o(recov_w)
    );

    cclk_gen #(.DIV_W(DIV_W), .PRE_W(PRE_W)) gen_i (
        .clk(clk), .rst_n(rst_n), .rate_i(rate_w), .start_i(start_w),
        .stop_i(stop_w), .sreset_i(sreset_w), .card_clk_o(card_clk),
        .running_o(clk_running)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_RATE:  rd_data = rate_w;
            A_STAT:  rd_data[STAT_RUN_BIT] = clk_running;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cclk_chk.sv
module cclk_chk (
    input logic clk,
    input logic rst_n,
    input logic card_clk,
    input logic clk_running,
    input logic sreset,
    input logic recov
);
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_running |-> !card_clk); // R5

    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_running) |-> card_clk); // R4

    AST_STOP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_running) && !$past(sreset)) |-> !$past(card_clk)); // R5

    AST_SRESET_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sreset) |-> !clk_running); // R8

    AST_RECOV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        recov |-> !clk_running); // R8
endmodule

bind cclk_top cclk_chk chk_i (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .clk_running(clk_running),
    .sreset(sreset_w), .recov(recov_w)
);

// File: tb/cclk_top_tb_top.sv
module cclk_top_tb_top;
    localparam int LIM = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        card_clk;
    logic        clk_running;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cclk_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .card_clk(card_clk), .clk_running(clk_running)
    );

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the capture edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    function automatic int period(input int d, input int p);
        int de, m;
        de = (d == 0) ? 2 : d + 1;
        m  = (p == 0) ? 1 : 2 * p;
        return de * m;
    endfunction

    // starts at a high sample; counts one high phase and one low phase
    task automatic measure(output int h, output int l);
        h = 0; l = 0;
        while (card_clk && h < LIM) begin h++; @(negedge clk); end
        while (!card_clk && clk_running && l < LIM) begin l++; @(negedge clk); end
    endtask

    task automatic stop_wait();
        int n;
        n = 0;
        wr(2'd0, 16'h0001);
        while (clk_running && n < LIM) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, h, l, pp, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R1 readback, R9 status
        chk("R10 clk low", int'(card_clk), 0);
        chk("R10 stopped", int'(clk_running), 0);
        rd(2'd1, v); chk("R10 rate default", v, 1);
        rd(2'd2, v); chk("R9 status idle", v, 0);
        rd(2'd0, v); chk("R1 ctrl reads zero", v, 0);

        // R2 R3 sweep of divider with small prescalers
        for (int p = 0; p < 3; p++) begin
            for (int d = 0; d < 16; d++) begin
                wr(2'd1, 16'((p << 4) | d));
                rd(2'd1, v); chk("R1 rate readback", v, (p << 4) | d);
                wr(2'd0, 16'h0002);
                chk("R4 high after start", int'(card_clk), 1);
                rd(2'd2, v); chk("R9 status running", v, 256);
                pp = period(d, p);
                measure(h, l);
                chk(d == 0 ? "R3 high div0" : "R2 high", h, pp / 2);
                chk(d == 0 ? "R3 low div0" : "R2 low", l, pp - pp / 2);
                stop_wait();
                chk("R5 stopped low", int'(card_clk), 0);
            end
        end

        // R2 prescaler power sweep
        for (int k = 0; k < 12; k++) begin
            wr(2'd1, 16'(((1 << k) << 4) | 1));
            wr(2'd0, 16'h0002);
            pp = period(1, 1 << k);
            measure(h, l);
            chk("R2 presc high", h, pp / 2);
            chk("R2 presc low", l, pp - pp / 2);
            stop_wait();
        end

        // R5 stop inside high phase: full period then stop
        wr(2'd1, 16'h0007);
        wr(2'd0, 16'h0002);
        wr(2'd0, 16'h0001);
        measure(h, l);
        chk("R5 full high after stop", h + 1, 4);
        chk("R5 full low after stop", l, 4);
        chk("R5 stopped status", int'(clk_running), 0);
        c = 0;
        for (int i = 0; i < 20; i++) begin c += int'(card_clk); @(negedge clk); end
        chk("R5 stays low", c, 0);
        wr(2'd0, 16'h0001);
        chk("R5 stop when stopped", int'(clk_running), 0);

        // R6 start and stop together while running
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0002);
        wr(2'd0, 16'h0003);
        repeat (12) @(negedge clk);
        chk("R6 still running", int'(clk_running), 1);
        while (!card_clk) @(negedge clk);
        stop_wait();

        // R7 rate change mid-period
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0002);
        wr(2'd1, 16'h0005);
        measure(h, l);
        chk("R7 old high", h + 1, 2);
        chk("R7 old low", l, 2);
        measure(h, l);
        chk("R7 new high", h, 3);
        chk("R7 new low", l, 3);
        stop_wait();

        // R8 soft reset sequence
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0002);
        repeat (2) @(negedge clk);
        wr(2'd0, 16'h0008);
        chk("R8 immediate stop", int'(clk_running), 0);
        chk("R8 clk low", int'(card_clk), 0);
        rd(2'd1, v); chk("R8 rate restored", v, 1);
        wr(2'd0, 16'h000A);
        chk("R8 reset+start ignored", int'(clk_running), 0);
        for (int i = 0; i < 7; i++) wr(2'd0, 16'h0002);
        chk("R8 held after seven", int'(clk_running), 0);
        wr(2'd0, 16'h0002);
        chk("R8 eighth starts", int'(clk_running), 1);
        chk("R8 eighth high", int'(card_clk), 1);
        measure(h, l);
        chk("R8 default high", h, 1);
        chk("R8 default low", l, 1);
        stop_wait();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule